// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation when the translation cache misses. A walk starts from a 32-bit virtual address and a table base. The walker reads a first-level (master) entry from memory, then a second-level entry, through a word-wide read port. Each read has a request/grant handshake for the address and a one-cycle valid pulse for the data. The walk ends in one of two ways: a one-cycle completion that delivers the second-level entry and the physical address, or a one-cycle fault that reports the failing level and the virtual address.

The virtual address is split into a 10-bit master index in bits 31:22, a 10-bit secondary index in bits 21:12 and a 12-bit page offset in bits 11:0. Every table entry is one 32-bit word, so a table of 1024 entries fills exactly one 4 KB page. Bit 0 of an entry is its valid flag and bits 31:12 hold a frame number. The walker reads no other entry bits. A master entry whose valid flag is clear makes the whole 4 MB region it covers absent. The walk then stops without reading a second word.

Top module: `pt_walk_top`

## Requirements
- R1: After reset the walker is idle: `walk_ready` is 1 and `mem_rd_req`, `done_vld` and `fault_vld` are 0. `walk_ready` is 1 only while idle, and no read is requested while idle.
- R2: The first read goes to `walk_base + 4*va[31:22]` (32-bit wrap). A read request and its address stay unchanged until `mem_rd_gnt` is seen high.
- R3: If bit 0 of the master word is 0, `fault_vld` pulses with `fault_lvl` = 0, and no second read is requested.
- R4: If the master word is valid, the second read goes to `{master[31:12], 12'h000} + 4*va[21:12]`.
- R5: If bit 0 of the second word is 0, `fault_vld` pulses with `fault_lvl` = 1.
- R6: If the second word is valid, `done_vld` pulses for one cycle. `done_pte` equals the second word, and `done_pa` equals `{second[31:12], va[11:0]}`.
- R7: `walk_req` is ignored while a walk is in progress. The walk in flight uses the address and base it accepted, and no further walk starts afterwards.
- R8: `done_vld` and `fault_vld` each last exactly one cycle, and the walker is idle in the next cycle. `fault_va` carries the accepted virtual address during a fault.
- R9: `done_vld` and `fault_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Start a walk (taken only when `walk_ready`) |
| walk_va | input | 32 | Virtual address to translate |
| walk_base | input | 32 | Byte address of the master table |
| walk_ready | output | 1 | Walker idle, able to take a request |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rd_vld | input | 1 | Read data valid pulse |
| mem_rd_data | input | 32 | Read data word |
| done_vld | output | 1 | Walk completed with a valid entry |
| done_pte | output | 32 | Second-level entry for the translation cache |
| done_pa | output | 32 | Physical address (frame and offset) |
| fault_vld | output | 1 | Walk ended with a page fault |
| fault_lvl | output | 1 | 0 = master entry invalid, 1 = second entry invalid |
| fault_va | output | 32 | Faulting virtual address |

## Verification
The assertions assume a well-behaved memory. It raises `mem_rd_gnt` only while a request is pending and raises `mem_rd_vld` only once per accepted request, after the grant. The stimulus keeps to this because the bench memory answers only after it sees `mem_rd_req`. It grants once after a random delay of zero to three cycles and returns exactly one data pulse after a further random delay. Entry values, addresses and bases come from a seeded random source, with directed walks for wrap-around bases, extreme addresses and both fault levels. Stray `walk_req` pulses are injected mid-walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int ENT_LG = 2;
  localparam int ENT_W  = 8 << ENT_LG;
  localparam int FRM_W  = VA_W - OFF_W;
  localparam int PAD_W  = VA_W - IDX_W - ENT_LG;
  localparam int VLD_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_M, ST_WT_M, ST_RD_S, ST_WT_S, ST_DONE, ST_FAULT
  } walk_st_e;

  function automatic logic [VA_W-1:0] idx_off(input logic [IDX_W-1:0] idx);
    return {{PAD_W{1'b0}}, idx, {ENT_LG{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] mst_addr(input logic [VA_W-1:0] base,
                                               input logic [VA_W-1:0] va);
    return base + idx_off(va[VA_W-1 -: IDX_W]);
  endfunction

  function automatic logic [VA_W-1:0] sec_addr(input logic [FRM_W-1:0] frm,
                                               input logic [VA_W-1:0] va);
    return {frm, {OFF_W{1'b0}}} + idx_off(va[OFF_W +: IDX_W]);
  endfunction

  function automatic logic [VA_W-1:0] phys(input logic [FRM_W-1:0] frm,
                                           input logic [OFF_W-1:0] off);
    return {frm, off};
  endfunction
endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic walk_req,
  input  logic mem_rd_gnt,
  input  logic mem_rd_vld,
  input  logic ent_valid,
  output logic walk_ready,
  output logic rd_req,
  output logic rd_second,
  output logic evt_accept,
  output logic evt_mst_cap,
  output logic evt_sec_cap,
  output logic done_vld,
  output logic fault_vld
);
  walk_st_e st_q, st_d;

  assign walk_ready  = (st_q == ST_IDLE);
  assign rd_req      = (st_q == ST_RD_M) || (st_q == ST_RD_S);
  assign rd_second   = (st_q == ST_RD_S);
  assign evt_accept  = walk_ready && walk_req;
  assign evt_mst_cap = (st_q == ST_WT_M) && mem_rd_vld;
  assign evt_sec_cap = (st_q == ST_WT_S) && mem_rd_vld;
  assign done_vld    = (st_q == ST_DONE);
  assign fault_vld   = (st_q == ST_FAULT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (walk_req)   st_d = ST_RD_M;
      ST_RD_M:  if (mem_rd_gnt) st_d = ST_WT_M;
      ST_WT_M:  if (mem_rd_vld) st_d = ent_valid ? ST_RD_S : ST_FAULT;
      ST_RD_S:  if (mem_rd_gnt) st_d = ST_WT_S;
      ST_WT_S:  if (mem_rd_vld) st_d = ent_valid ? ST_DONE : ST_FAULT;
      ST_DONE:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R1
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !rd_req);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !mem_rd_gnt |=> rd_req && $stable(rd_second));
  // R3
  mst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mst_cap && !ent_valid |=> fault_vld && !rd_req);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> !done_vld && walk_ready);
  // R8
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vld |=> !fault_vld && walk_ready);
  // R9
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_vld && fault_vld));
endmodule

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_accept,
  input  logic             evt_mst_cap,
  input  logic             evt_sec_cap,
  input  logic             rd_req,
  input  logic             rd_second,
  input  logic [VA_W-1:0]  walk_va,
  input  logic [VA_W-1:0]  walk_base,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic [VA_W-1:0]  mem_rd_addr,
  output logic [ENT_W-1:0] done_pte,
  output logic [VA_W-1:0]  done_pa,
  output logic             fault_lvl,
  output logic [VA_W-1:0]  fault_va
);
  logic [VA_W-1:0]  va_q, base_q;
  logic [FRM_W-1:0] mst_frm_q;
  logic [ENT_W-1:0] sec_q;
  logic             lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q      <= '0;
      base_q    <= '0;
      mst_frm_q <= '0;
      sec_q     <= '0;
      lvl_q     <= 1'b0;
    end else begin
      if (evt_accept) begin
        va_q   <= walk_va;
        base_q <= walk_base;
        lvl_q  <= 1'b0;
      end
      if (evt_mst_cap) mst_frm_q <= mem_rd_data[ENT_W-1 -: FRM_W];
      if (evt_sec_cap) begin
        sec_q <= mem_rd_data;
        lvl_q <= 1'b1;
      end
    end
  end

  assign mem_rd_addr = rd_second ? sec_addr(mst_frm_q, va_q) : mst_addr(base_q, va_q);
  assign done_pte    = sec_q;
  assign done_pa     = phys(sec_q[ENT_W-1 -: FRM_W], va_q[OFF_W-1:0]);
  assign fault_lvl   = lvl_q;
  assign fault_va    = va_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && $past(rd_req) && $stable(rd_second) |-> $stable(mem_rd_addr));
  // R7
  va_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $stable(va_q));
  // R6
  pa_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sec_cap |=> done_pa[OFF_W-1:0] == fault_va[OFF_W-1:0]);
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
  import pt_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_req,
  input  logic [VA_W-1:0]  walk_va,
  input  logic [VA_W-1:0]  walk_base,
  output logic             walk_ready,
  output logic             mem_rd_req,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_gnt,
  input  logic             mem_rd_vld,
  input  logic [ENT_W-1:0] mem_rd_data,
  output logic             done_vld,
  output logic [ENT_W-1:0] done_pte,
  output logic [VA_W-1:0]  done_pa,
  output logic             fault_vld,
  output logic             fault_lvl,
  output logic [VA_W-1:0]  fault_va
);
  logic rd_second, evt_accept, evt_mst_cap, evt_sec_cap;

  pt_walk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .walk_req(walk_req),
    .mem_rd_gnt(mem_rd_gnt), .mem_rd_vld(mem_rd_vld),
    .ent_valid(mem_rd_data[VLD_BIT]),
    .walk_ready(walk_ready), .rd_req(mem_rd_req), .rd_second(rd_second),
    .evt_accept(evt_accept), .evt_mst_cap(evt_mst_cap), .evt_sec_cap(evt_sec_cap),
    .done_vld(done_vld), .fault_vld(fault_vld)
  );

  pt_walk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .evt_accept(evt_accept),
    .evt_mst_cap(evt_mst_cap), .evt_sec_cap(evt_sec_cap),
    .rd_req(mem_rd_req), .rd_second(rd_second),
    .walk_va(walk_va), .walk_base(walk_base), .mem_rd_data(mem_rd_data),
    .mem_rd_addr(mem_rd_addr), .done_pte(done_pte), .done_pa(done_pa),
    .fault_lvl(fault_lvl), .fault_va(fault_va)
  );
endmodule

// File: tb/sim_pt_walk_top.sv
`timescale 1ns/1ps
module sim_pt_walk_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic walk_req = 1'b0, mem_rd_gnt = 1'b0, mem_rd_vld = 1'b0;
  logic [31:0] walk_va = '0, walk_base = '0, mem_rd_data = '0;
  logic walk_ready, mem_rd_req, done_vld, fault_vld, fault_lvl;
  logic [31:0] mem_rd_addr, done_pte, done_pa, fault_va;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pt_walk_top u0 (.*);

  function automatic logic [31:0] exp_mst(input logic [31:0] b, input logic [31:0] v);
    return b + (v >> 22) * 32'd4;
  endfunction
  function automatic logic [31:0] exp_sec(input logic [31:0] m, input logic [31:0] v);
    return (m & 32'hFFFF_F000) + (((v >> 12) & 32'h3FF) << 2);
  endfunction
  function automatic logic [31:0] exp_pa(input logic [31:0] s, input logic [31:0] v);
    return (s & 32'hFFFF_F000) | (v & 32'h0000_0FFF);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic serve(input string rq, input logic [31:0] exp_addr,
                       input logic [31:0] data, input bit noise);
    int w = 0;
    while (!mem_rd_req && w < 20) begin @(negedge clk); w++; end
    chk(rq, {31'b0, mem_rd_req}, 32'd1);
    chk(rq, mem_rd_addr, exp_addr);
    for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
      if (noise) begin walk_req = 1'b1; walk_va = $urandom; walk_base = $urandom; end
      @(negedge clk);
      chk("R2", {31'b0, mem_rd_req}, 32'd1);
      chk("R2", mem_rd_addr, exp_addr);
    end
    walk_req = 1'b0;
    mem_rd_gnt = 1'b1;
    @(negedge clk);
    mem_rd_gnt = 1'b0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    mem_rd_vld = 1'b1; mem_rd_data = data;
    @(negedge clk);
    mem_rd_vld = 1'b0; mem_rd_data = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] me, input logic [31:0] se, input bit noise);
    walk_req = 1'b1; walk_va = va; walk_base = base;
    @(negedge clk);
    walk_req = 1'b0;
    chk("R1", {31'b0, walk_ready}, 32'd0);
    serve("R2", exp_mst(base, va), me, noise);
    if (!me[0]) begin
      chk("R3", {31'b0, fault_vld}, 32'd1);
      chk("R3", {31'b0, fault_lvl}, 32'd0);
      chk("R3", {31'b0, mem_rd_req}, 32'd0);
      chk("R8", fault_va, va);
      chk("R9", {31'b0, done_vld}, 32'd0);
    end else begin
      serve("R4", exp_sec(me, va), se, noise);
      if (se[0]) begin
        chk("R6", {31'b0, done_vld}, 32'd1);
        chk("R6", done_pte, se);
        chk("R6", done_pa, exp_pa(se, va));
        chk("R9", {31'b0, fault_vld}, 32'd0);
      end else begin
        chk("R5", {31'b0, fault_vld}, 32'd1);
        chk("R5", {31'b0, fault_lvl}, 32'd1);
        chk("R8", fault_va, va);
        chk("R9", {31'b0, done_vld}, 32'd0);
      end
    end
    @(negedge clk);
    chk("R8", {29'b0, done_vld, fault_vld, walk_ready}, 32'd1);
    @(negedge clk);
    chk("R7", {31'b0, mem_rd_req}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'b0, walk_ready, mem_rd_req, done_vld, fault_vld}, 32'b1000);
    // directed corners
    walk(32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hABCD_E001, 32'h1234_5007, 1'b0);
    walk(32'h0000_0000, 32'h0000_1000, 32'h0000_2000, 32'h0, 1'b0);
    walk(32'h0001_8007, 32'h0040_0000, 32'h0050_0001, 32'h0014_8001, 1'b1);
    walk(32'h0001_8007, 32'h0040_0000, 32'h0050_0001, 32'h0014_8000, 1'b1);
    walk(32'h8000_0ABC, 32'h0000_0004, 32'hFFFF_F0FF, 32'hFFFF_FFFF, 1'b1);
    // random walks
    for (int n = 0; n < 60; n++) begin
      logic [31:0] me, se;
      me = $urandom; se = $urandom;
      me[0] = ($urandom_range(0, 3) != 0);
      se[0] = ($urandom_range(0, 3) != 0);
      walk($urandom, $urandom, me, se, $urandom_range(0, 1) == 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule